// File: doc/BRIEF.md
# Partial-Register Rename Tracker

This block keeps, for every architectural integer register and each of its narrower views, the tag of the youngest in-flight instruction that defines it. Each full-width register owns four views: the whole register, its low 32 bits, its low 16 bits and its low byte. Each narrower view lies inside every wider one. On each write, the block decides whether the destination gets its own physical register or must stay fused with its full-width parent. When it stays fused, the write inherits a false dependency on whoever last wrote that parent. The block reports that dependency tag to the scheduler, together with a strobe that tells the free list whether a physical register must be taken.

Every write request falls into one of three named classes. **WK_RENAME**: the view's kind is marked independently renameable by a parameter. **WK_WIDEN**: the write zeroes everything above its width. **WK_MERGE**: any other write to a fused view. A retire-side remove request clears entries that still name the retiring tag. A lookup port returns the current producer of any view. A small combinational gate decides when a fused partial write may issue, given how many cycles its parent writer still needs.

Top module: `prt_rename_table`

## Requirements
- R1: After reset, every entry is invalid, and the lookup port returns valid 0 for every register id.
- R2: A register id is {group, kind}, with kind in the two low bits: 0 = full 64-bit, 1 = low 32, 2 = low 16, 3 = low byte. The group count is a power of two, and kind k contains every kind numbered above it.
- R3: A non-clearing write whose kind is marked renameable (by default only kind 0) asserts alloc, reports no dependency, and one cycle later its kind and all higher-numbered kinds of the group return its tag.
- R4: A write with the clear-upper flag set, of any kind, asserts alloc, reports no dependency, and one cycle later all four kinds of its group return its tag.
- R5: A non-clearing write to a non-renameable kind does not assert alloc. It reports a dependency with the tag held by the group's kind-0 entry when that entry is valid, and none when it is invalid. One cycle later all four kinds of the group return its tag.
- R6: No dependency is reported when the kind-0 entry already holds the same tag as the write, including a tag placed there by an older port in the same cycle.
- R7: Write port 0 is older than port 1 in the same cycle. Port 1 sees port 0's update when it looks for a dependency, and port 1's tag wins on entries both ports touch.
- R8: A remove clears only entries whose tag equals the remove tag. The entries it may clear are chosen by the write rules: a renameable non-clearing remove covers its kind and higher kinds; a clearing or fused remove covers all four kinds of the group. A remove is applied before same-cycle writes.
- R9: rm_free is asserted for every remove except a non-clearing remove of a non-renameable kind.
- R10: When a write and a remove hit the same entry in the same cycle, the entry afterwards holds the write's tag.
- R11: rdy_ok is 1 only if rdy_uses is 1. In addition, either no dependency is present, or the dependency's remaining latency is known and strictly less than rdy_maxlat. An unknown latency gives 0.
- R12: The lookup port is combinational on the stored table: during a write cycle it still shows the previous producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | WR_PORTS | Write request per port |
| wr_reg | input | WR_PORTS x REG_W | Destination register id per port |
| wr_tag | input | WR_PORTS x TAG_W | Instruction tag per port |
| wr_clr | input | WR_PORTS | Write zeroes bits above its width |
| wr_alloc | output | WR_PORTS | Take a physical register for this write |
| wr_dep_vld | output | WR_PORTS | False dependency present |
| wr_dep_tag | output | WR_PORTS x TAG_W | Tag of the writer depended on |
| rm_en | input | 1 | Remove request |
| rm_reg | input | REG_W | Register id of the retiring write |
| rm_tag | input | TAG_W | Tag of the retiring write |
| rm_clr | input | 1 | Retiring write cleared upper bits |
| rm_free | output | 1 | Return a physical register |
| lk_reg | input | REG_W | Lookup register id |
| lk_vld | output | 1 | A producer is in flight |
| lk_tag | output | TAG_W | Producer tag |
| rdy_uses | input | 1 | All source operands ready |
| rdy_dep_vld | input | 1 | Candidate has a false dependency |
| rdy_left_known | input | 1 | Dependency's remaining latency is known |
| rdy_left | input | LAT_W | Dependency's remaining latency |
| rdy_maxlat | input | LAT_W | Candidate's own maximum latency |
| rdy_ok | output | 1 | Candidate may issue |

## Verification
The bench drives full-width writes, fused byte and word writes to groups that are empty and to groups that are occupied, and clearing 32-bit writes. This separates the three write classes by their alloc and dependency outputs and by the spread of the tag across the group. Paired same-cycle writes, with different tags and then with an equal tag, show port ordering and the same-instruction suppression. Removes with matching and stale tags, with fused, full and clearing kinds, show the tag-guarded clear and the free strobe. A remove and a write colliding on one entry shows that the write wins. The ready gate is tried with unknown, smaller and equal latencies, so that the strict comparison is exposed.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int SUBS   = 4;
    localparam int KIND_W = 2;

    typedef enum logic [1:0] {
        WK_RENAME = 2'd0,
        WK_WIDEN  = 2'd1,
        WK_MERGE  = 2'd2
    } wkind_e;

    // kinds numbered at or above k lie inside kind k
    function automatic logic [SUBS-1:0] kind_and_below(input logic [KIND_W-1:0] k);
        logic [SUBS-1:0] m;
        for (int i = 0; i < SUBS; i++) begin
            m[i] = (KIND_W'(i) >= k);
        end
        return m;
    endfunction

endpackage

// File: rtl/prt_classify.sv
module prt_classify
    import prt_pkg::*;
#(
    parameter int              REG_W      = 4,
    parameter logic [SUBS-1:0] RENAMEABLE = 4'b0001
) (
    input  logic [REG_W-1:0] reg_id,
    input  logic             clr_upper,
    output logic [SUBS-1:0]  touch_mask,
    output logic             takes_phys
);

    wkind_e              cls;
    logic [KIND_W-1:0]   kind;

    assign kind = reg_id[KIND_W-1:0];

    always_comb begin
        if (clr_upper) begin
            cls = WK_WIDEN;
        end else if (RENAMEABLE[kind]) begin
            cls = WK_RENAME;
        end else begin
            cls = WK_MERGE;
        end
    end

    always_comb begin
        unique case (cls)
            WK_RENAME: begin
                touch_mask = kind_and_below(kind);
                takes_phys = 1'b1;
            end
            WK_WIDEN: begin
                touch_mask = '1;
                takes_phys = 1'b1;
            end
            WK_MERGE: begin
                touch_mask = '1;
                takes_phys = 1'b0;
            end
            default: begin
                touch_mask = '1;
                takes_phys = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/prt_ready_gate.sv
module prt_ready_gate #(
    parameter int LAT_W = 4
) (
    input  logic             uses_ready,
    input  logic             dep_vld,
    input  logic             left_known,
    input  logic [LAT_W-1:0] left_cycles,
    input  logic [LAT_W-1:0] max_lat,
    output logic             may_issue
);

    logic dep_clear;

    always_comb begin
        if (!dep_vld) begin
            dep_clear = 1'b1;
        end else if (!left_known) begin
            dep_clear = 1'b0;
        end else begin
            dep_clear = (left_cycles < max_lat);
        end
        may_issue = uses_ready && dep_clear;
    end

endmodule

// File: rtl/prt_rename_table.sv
module prt_rename_table
    import prt_pkg::*;
#(
    parameter int              GPRS       = 4,
    parameter int              TAG_W      = 6,
    parameter int              LAT_W      = 4,
    parameter int              WR_PORTS   = 2,
    parameter logic [SUBS-1:0] RENAMEABLE = 4'b0001,
    localparam int             REG_W      = $clog2(GPRS) + KIND_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [WR_PORTS-1:0]            wr_en,
    input  logic [WR_PORTS-1:0][REG_W-1:0] wr_reg,
    input  logic [WR_PORTS-1:0][TAG_W-1:0] wr_tag,
    input  logic [WR_PORTS-1:0]            wr_clr,
    output logic [WR_PORTS-1:0]            wr_alloc,
    output logic [WR_PORTS-1:0]            wr_dep_vld,
    output logic [WR_PORTS-1:0][TAG_W-1:0] wr_dep_tag,
    input  logic                           rm_en,
    input  logic [REG_W-1:0]               rm_reg,
    input  logic [TAG_W-1:0]               rm_tag,
    input  logic                           rm_clr,
    output logic                           rm_free,
    input  logic [REG_W-1:0]               lk_reg,
    output logic                           lk_vld,
    output logic [TAG_W-1:0]               lk_tag,
    input  logic                           rdy_uses,
    input  logic                           rdy_dep_vld,
    input  logic                           rdy_left_known,
    input  logic [LAT_W-1:0]               rdy_left,
    input  logic [LAT_W-1:0]               rdy_maxlat,
    output logic                           rdy_ok
);

    localparam int ENTS  = 1 << REG_W;
    localparam int GRP_W = REG_W - KIND_W;

    logic [ENTS-1:0]  v_q,   v_n;
    logic [TAG_W-1:0] tag_q [ENTS];
    logic [TAG_W-1:0] tag_n [ENTS];

    logic [WR_PORTS-1:0][SUBS-1:0] wmask;
    logic [WR_PORTS-1:0]           wphys;
    logic [SUBS-1:0]               rmask;
    logic                          rphys;

    logic [REG_W-1:0] ix;
    logic [REG_W-1:0] full_ix;

    // one classifier per write port, one for the remove port
    for (genvar p = 0; p < WR_PORTS; p++) begin : g_wcls
        prt_classify #(.REG_W(REG_W), .RENAMEABLE(RENAMEABLE)) u_cls (
            .reg_id     (wr_reg[p]),
            .clr_upper  (wr_clr[p]),
            .touch_mask (wmask[p]),
            .takes_phys (wphys[p])
        );
    end

    prt_classify #(.REG_W(REG_W), .RENAMEABLE(RENAMEABLE)) u_rcls (
        .reg_id     (rm_reg),
        .clr_upper  (rm_clr),
        .touch_mask (rmask),
        .takes_phys (rphys)
    );

    // remove first, then writes in port order (port 0 oldest)
    always_comb begin
        v_n = v_q;
        for (int e = 0; e < ENTS; e++) begin
            tag_n[e] = tag_q[e];
        end
        ix      = '0;
        full_ix = '0;
        if (rm_en) begin
            for (int s = 0; s < SUBS; s++) begin
                ix = {rm_reg[REG_W-1:KIND_W], KIND_W'(s)};
                if (rmask[s] && v_n[ix] && (tag_n[ix] == rm_tag)) begin
                    v_n[ix] = 1'b0;
                end
            end
        end
        for (int p = 0; p < WR_PORTS; p++) begin
            full_ix       = {wr_reg[p][REG_W-1:KIND_W], KIND_W'(0)};
            wr_alloc[p]   = wr_en[p] && wphys[p];
            wr_dep_vld[p] = wr_en[p] && !wphys[p] && v_n[full_ix]
                            && (tag_n[full_ix] != wr_tag[p]);
            wr_dep_tag[p] = wr_dep_vld[p] ? tag_n[full_ix] : '0;
            if (wr_en[p]) begin
                for (int s = 0; s < SUBS; s++) begin
                    ix = {wr_reg[p][REG_W-1:KIND_W], KIND_W'(s)};
                    if (wmask[p][s]) begin
                        v_n[ix]   = 1'b1;
                        tag_n[ix] = wr_tag[p];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int e = 0; e < ENTS; e++) begin
                tag_q[e] <= '0;
            end
        end else begin
            v_q <= v_n;
            for (int e = 0; e < ENTS; e++) begin
                tag_q[e] <= tag_n[e];
            end
        end
    end

    assign rm_free = rm_en && rphys;
    assign lk_vld  = v_q[lk_reg];
    assign lk_tag  = v_q[lk_reg] ? tag_q[lk_reg] : '0;

    prt_ready_gate #(.LAT_W(LAT_W)) u_gate (
        .uses_ready  (rdy_uses),
        .dep_vld     (rdy_dep_vld),
        .left_known  (rdy_left_known),
        .left_cycles (rdy_left),
        .max_lat     (rdy_maxlat),
        .may_issue   (rdy_ok)
    );

    // R3 R5 R7: youngest port's destination holds its tag next cycle
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[WR_PORTS-1] |=> v_q[$past(wr_reg[WR_PORTS-1])]
            && (tag_q[$past(wr_reg[WR_PORTS-1])] == $past(wr_tag[WR_PORTS-1])));

    for (genvar p = 0; p < WR_PORTS; p++) begin : g_wchk
        // R5
        dep_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_dep_vld[p] |-> !wr_alloc[p]);
        // R6
        dep_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_dep_vld[p] |-> (wr_dep_tag[p] != wr_tag[p]));
    end

    for (genvar e = 0; e < ENTS; e++) begin : g_echk
        // R8
        rm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rm_en && !(|wr_en) && (tag_q[e] != rm_tag)) |=> $stable(v_q[e]));
    end

    // R11
    ready_uses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_ok |-> rdy_uses);

    // R9
    free_only_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_free |-> rm_en);

endmodule

// File: tb/sim_prt_rename_table.sv
module sim_prt_rename_table;

    localparam int RW = 4;
    localparam int TW = 6;
    localparam int LW = 4;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NP-1:0]         wr_en = '0;
    logic [NP-1:0][RW-1:0] wr_reg = '0;
    logic [NP-1:0][TW-1:0] wr_tag = '0;
    logic [NP-1:0]         wr_clr = '0;
    logic [NP-1:0]         wr_alloc;
    logic [NP-1:0]         wr_dep_vld;
    logic [NP-1:0][TW-1:0] wr_dep_tag;
    logic                  rm_en = 1'b0;
    logic [RW-1:0]         rm_reg = '0;
    logic [TW-1:0]         rm_tag = '0;
    logic                  rm_clr = 1'b0;
    logic                  rm_free;
    logic [RW-1:0]         lk_reg = '0;
    logic                  lk_vld;
    logic [TW-1:0]         lk_tag;
    logic                  rdy_uses = 1'b0;
    logic                  rdy_dep_vld = 1'b0;
    logic                  rdy_left_known = 1'b0;
    logic [LW-1:0]         rdy_left = '0;
    logic [LW-1:0]         rdy_maxlat = '0;
    logic                  rdy_ok;

    prt_rename_table u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_tag(wr_tag), .wr_clr(wr_clr),
        .wr_alloc(wr_alloc), .wr_dep_vld(wr_dep_vld), .wr_dep_tag(wr_dep_tag),
        .rm_en(rm_en), .rm_reg(rm_reg), .rm_tag(rm_tag), .rm_clr(rm_clr),
        .rm_free(rm_free),
        .lk_reg(lk_reg), .lk_vld(lk_vld), .lk_tag(lk_tag),
        .rdy_uses(rdy_uses), .rdy_dep_vld(rdy_dep_vld),
        .rdy_left_known(rdy_left_known), .rdy_left(rdy_left),
        .rdy_maxlat(rdy_maxlat), .rdy_ok(rdy_ok)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rid(input int g, input int k);
        return g * 4 + k;
    endfunction

    task automatic idle();
        wr_en  = '0;
        wr_clr = '0;
        rm_en  = 1'b0;
        rm_clr = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wset(input int p, input int r, input int t, input bit c);
        wr_en[p]  = 1'b1;
        wr_reg[p] = RW'(r);
        wr_tag[p] = TW'(t);
        wr_clr[p] = c;
    endtask

    task automatic rset(input int r, input int t, input bit c);
        rm_en  = 1'b1;
        rm_reg = RW'(r);
        rm_tag = TW'(t);
        rm_clr = c;
    endtask

    task automatic look(input string req, input int r, input int ev, input int et);
        lk_reg = RW'(r);
        #1;
        chk_eq(req, int'(lk_vld), ev);
        if (ev != 0) chk_eq(req, int'(lk_tag), et);
    endtask

    task automatic t_reset();
        int seen = 0;
        for (int r = 0; r < 16; r++) begin
            lk_reg = RW'(r);
            #1;
            seen += int'(lk_vld);
        end
        chk_eq("R1 valid count", seen, 0);
    endtask

    task automatic t_full_write();
        wset(0, rid(0, 0), 5, 1'b0);
        #1;
        chk_eq("R3 alloc", int'(wr_alloc[0]), 1);
        chk_eq("R3 dep", int'(wr_dep_vld[0]), 0);
        tick();
        look("R2/R3 byte view", rid(0, 3), 1, 5);
        look("R3 full view", rid(0, 0), 1, 5);
    endtask

    task automatic t_merged();
        wset(0, rid(0, 2), 9, 1'b0);
        #1;
        chk_eq("R5 alloc", int'(wr_alloc[0]), 0);
        chk_eq("R5 dep vld", int'(wr_dep_vld[0]), 1);
        chk_eq("R5 dep tag", int'(wr_dep_tag[0]), 5);
        look("R12 old producer", rid(0, 0), 1, 5);
        tick();
        look("R5 parent", rid(0, 0), 1, 9);
        look("R5 byte", rid(0, 3), 1, 9);
        wset(0, rid(1, 3), 3, 1'b0);
        #1;
        chk_eq("R5 empty dep", int'(wr_dep_vld[0]), 0);
        chk_eq("R5 empty alloc", int'(wr_alloc[0]), 0);
        tick();
    endtask

    task automatic t_clear();
        wset(0, rid(0, 1), 12, 1'b1);
        #1;
        chk_eq("R4 alloc", int'(wr_alloc[0]), 1);
        chk_eq("R4 dep", int'(wr_dep_vld[0]), 0);
        tick();
        look("R4 full", rid(0, 0), 1, 12);
        look("R4 word", rid(0, 2), 1, 12);
    endtask

    task automatic t_same_tag();
        wset(0, rid(0, 3), 12, 1'b0);
        #1;
        chk_eq("R6 same tag dep", int'(wr_dep_vld[0]), 0);
        tick();
    endtask

    task automatic t_dual();
        wset(0, rid(2, 0), 20, 1'b0);
        wset(1, rid(2, 2), 21, 1'b0);
        #1;
        chk_eq("R7 port0 alloc", int'(wr_alloc[0]), 1);
        chk_eq("R7 port1 alloc", int'(wr_alloc[1]), 0);
        chk_eq("R7 port1 dep vld", int'(wr_dep_vld[1]), 1);
        chk_eq("R7 port1 dep tag", int'(wr_dep_tag[1]), 20);
        tick();
        look("R7 younger wins", rid(2, 0), 1, 21);
        wset(0, rid(3, 0), 30, 1'b0);
        wset(1, rid(3, 3), 30, 1'b0);
        #1;
        chk_eq("R6 same-cycle same tag", int'(wr_dep_vld[1]), 0);
        tick();
    endtask

    task automatic t_remove();
        rset(rid(0, 3), 7, 1'b0);
        #1;
        chk_eq("R9 fused no free", int'(rm_free), 0);
        tick();
        look("R8 stale tag kept", rid(0, 0), 1, 12);
        rset(rid(0, 0), 12, 1'b0);
        #1;
        chk_eq("R9 full frees", int'(rm_free), 1);
        tick();
        look("R8 cleared word", rid(0, 2), 0, 0);
        look("R8 cleared full", rid(0, 0), 0, 0);
        rset(rid(2, 3), 21, 1'b0);
        #1;
        chk_eq("R9 fused byte no free", int'(rm_free), 0);
        tick();
        look("R8 fused clears parent", rid(2, 0), 0, 0);
        rset(rid(1, 1), 3, 1'b1);
        #1;
        chk_eq("R9 clearing frees", int'(rm_free), 1);
        tick();
        look("R8 clearing covers group", rid(1, 0), 0, 0);
        look("R8 clearing covers byte", rid(1, 3), 0, 0);
    endtask

    task automatic t_collide();
        rset(rid(3, 0), 30, 1'b0);
        wset(0, rid(3, 0), 40, 1'b0);
        tick();
        look("R10 write wins full", rid(3, 0), 1, 40);
        look("R10 write wins word", rid(3, 2), 1, 40);
    endtask

    task automatic t_ready();
        rdy_uses = 1'b0; rdy_dep_vld = 1'b0;
        #1; chk_eq("R11 uses pending", int'(rdy_ok), 0);
        rdy_uses = 1'b1;
        #1; chk_eq("R11 no dep", int'(rdy_ok), 1);
        rdy_dep_vld = 1'b1; rdy_left_known = 1'b0; rdy_left = 4'd0; rdy_maxlat = 4'd4;
        #1; chk_eq("R11 unknown latency", int'(rdy_ok), 0);
        rdy_left_known = 1'b1; rdy_left = 4'd3;
        #1; chk_eq("R11 smaller latency", int'(rdy_ok), 1);
        rdy_left = 4'd4;
        #1; chk_eq("R11 equal latency", int'(rdy_ok), 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_merged();
        t_clear();
        t_same_tag();
        t_dual();
        t_remove();
        t_collide();
        t_ready();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule